// File: doc/BRIEF.md
# DMA Region Access Checker

This block guards the read and write request buses of a DMA engine. It holds a small set of address windows, each a whole number of 4 KB pages, and gives each one an access permission and a mask of the channels it applies to. Every request carries a channel number, a byte address, a length and a direction. One cycle later the checker either passes the request downstream or blocks it.

A blocked request raises a one-cycle error pulse for an external error aggregator. The first blocked request is also captured in sticky status: its address, its channel and its direction. That status stays put until software clears it. Windows are programmed through a plain register write port. A global enable switches the whole check on or off. When it is off, every request passes.

The read and write buses are checked by separate logic in the same cycle. A channel may appear in any number of windows, and a window may serve any number of channels.

Top module: `dma_region_guard`

## Requirements
- R1: After reset all pass, block, error and fault-valid outputs are 0. All windows are reset to permission 0 and an empty channel mask.
- R2: With `prot_en` low, every request is passed one cycle later. No request is blocked, no error pulse is raised and the fault status does not change.
- R3: With `prot_en` high, a request is passed when some window meets all of these conditions: its mask bit for the request's channel is set, it grants the direction, and it holds every byte from `addr` to `addr+len`. A window holds a byte when the byte's page number (address bits 31:12) lies between the window's first page and last page, both inclusive.
- R4: A request whose last byte falls beyond a window's last page is not covered by that window. Example: with a window of pages 0x200E0 to 0x200E0, a write of 4 bytes at 0x200E0FFC passes, while a write of 5 or more bytes at that address is blocked. A request whose last byte passes the top of the address space is also blocked.
- R5: Permission code 0 grants nothing. Code 1 grants reads only. Codes 2 and 3 grant reads and writes.
- R6: A window applies to a channel only when mask bit `ch` is set. Several windows may enable one channel, and one window may enable several channels. A channel number of NCH or above is always blocked while the check is enabled.
- R7: Coverage comes from one window alone. A request that spans two adjacent windows is blocked even when each window would grant it, and a window whose last page is below its first page holds nothing.
- R8: A request sampled at a clock edge produces exactly one of pass or block on its bus in the next cycle. A cycle with no request produces neither. A blocked request never asserts the pass strobe.
- R9: `err_o` pulses in the cycle after any blocked request. The first blocked request while `flt_valid` is low latches its address, channel and direction, and sets `flt_valid`. Later faults leave the status unchanged until `flt_clr` clears it. When a read and a write fault together, the read is recorded. A fault in the same cycle as `flt_clr` is recorded.
- R10: The read and write buses are decided independently in the same cycle.
- R11: A configuration write takes field 0 as the first page, field 1 as the last page, field 2 as the permission in bits 1:0, and field 3 as the channel mask, for window `cfg_sel`. Page numbers are taken from the low bits of `cfg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_en | input | 1 | Global enable for the check |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | RW | Window index |
| cfg_fld | input | 2 | Field: 0 first page, 1 last page, 2 permission, 3 channel mask |
| cfg_wdata | input | AW | Write data |
| rd_req | input | 1 | Read request valid |
| rd_ch | input | CW | Read channel |
| rd_addr | input | AW | Read byte address |
| rd_len | input | LW | Read length minus one, in bytes |
| wr_req | input | 1 | Write request valid |
| wr_ch | input | CW | Write channel |
| wr_addr | input | AW | Write byte address |
| wr_len | input | LW | Write length minus one, in bytes |
| rd_pass | output | 1 | Read allowed, forwarded downstream |
| rd_blk | output | 1 | Read blocked |
| wr_pass | output | 1 | Write allowed, forwarded downstream |
| wr_blk | output | 1 | Write blocked |
| err_o | output | 1 | Error pulse to the aggregator |
| flt_clr | input | 1 | Clears the sticky fault status |
| flt_valid | output | 1 | A fault has been recorded |
| flt_addr | output | AW | Address of the recorded fault |
| flt_ch | output | CW | Channel of the recorded fault |
| flt_wr | output | 1 | Recorded fault was a write |

## Verification
A bad window register or a wrong compare shows up as a flipped pass/block decision on the very next cycle, but only for addresses near that window's edges. For this reason the sweep probes every page boundary with several offsets and lengths on every channel. A fault latch that is overwritten, or that is never set, shows up in `flt_addr` or `flt_valid` one cycle after the offending request. These fields are compared after every request, so a latch that drifts later is caught when it drifts.

// File: rtl/dma_region_guard.sv
module dma_region_guard #(
  parameter int NREG = 16,
  parameter int NCH  = 10,
  parameter int AW   = 32,
  parameter int LW   = 3,
  parameter int PG   = 12,
  localparam int PW  = AW - PG,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_en,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_sel,
  input  logic [1:0]    cfg_fld,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          rd_req,
  input  logic [CW-1:0] rd_ch,
  input  logic [AW-1:0] rd_addr,
  input  logic [LW-1:0] rd_len,
  input  logic          wr_req,
  input  logic [CW-1:0] wr_ch,
  input  logic [AW-1:0] wr_addr,
  input  logic [LW-1:0] wr_len,
  output logic          rd_pass,
  output logic          rd_blk,
  output logic          wr_pass,
  output logic          wr_blk,
  output logic          err_o,
  input  logic          flt_clr,
  output logic          flt_valid,
  output logic [AW-1:0] flt_addr,
  output logic [CW-1:0] flt_ch,
  output logic          flt_wr
);

  logic [PW-1:0]  r_lo   [NREG];
  logic [PW-1:0]  r_hi   [NREG];
  logic [1:0]     r_perm [NREG];
  logic [NCH-1:0] r_mask [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        r_lo[i]   <= '0;
        r_hi[i]   <= '0;
        r_perm[i] <= '0;
        r_mask[i] <= '0;
      end
    end else if (cfg_we && int'(cfg_sel) < NREG) begin
      case (cfg_fld)
        2'd0: r_lo[cfg_sel]   <= cfg_wdata[PW-1:0];
        2'd1: r_hi[cfg_sel]   <= cfg_wdata[PW-1:0];
        2'd2: r_perm[cfg_sel] <= cfg_wdata[1:0];
        default: r_mask[cfg_sel] <= cfg_wdata[NCH-1:0];
      endcase
    end
  end

  logic [AW:0] rd_last, wr_last;
  assign rd_last = {1'b0, rd_addr} + {{(AW+1-LW){1'b0}}, rd_len};
  assign wr_last = {1'b0, wr_addr} + {{(AW+1-LW){1'b0}}, wr_len};

  logic rd_ch_ok, wr_ch_ok;
  assign rd_ch_ok = int'(rd_ch) < NCH;
  assign wr_ch_ok = int'(wr_ch) < NCH;

  logic [NREG-1:0] rd_hit, wr_hit;
  for (genvar g = 0; g < NREG; g++) begin : g_win
    logic rd_in, wr_in;
    assign rd_in = rd_addr[AW-1:PG] >= r_lo[g] && rd_last[AW:PG] <= {1'b0, r_hi[g]};
    assign wr_in = wr_addr[AW-1:PG] >= r_lo[g] && wr_last[AW:PG] <= {1'b0, r_hi[g]};
    assign rd_hit[g] = rd_ch_ok && r_mask[g][rd_ch] && (r_perm[g] != 2'd0) && rd_in;
    assign wr_hit[g] = wr_ch_ok && r_mask[g][wr_ch] && r_perm[g][1] && wr_in;
  end

  logic rd_bad, wr_bad;
  assign rd_bad = rd_req && prot_en && !(|rd_hit);
  assign wr_bad = wr_req && prot_en && !(|wr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pass <= 1'b0;
      rd_blk  <= 1'b0;
      wr_pass <= 1'b0;
      wr_blk  <= 1'b0;
    end else begin
      rd_pass <= rd_req && !rd_bad;
      rd_blk  <= rd_bad;
      wr_pass <= wr_req && !wr_bad;
      wr_blk  <= wr_bad;
    end
  end

  assign err_o = rd_blk | wr_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_addr  <= '0;
      flt_ch    <= '0;
      flt_wr    <= 1'b0;
    end else begin
      if (flt_clr) flt_valid <= 1'b0;
      if ((!flt_valid || flt_clr) && (rd_bad || wr_bad)) begin
        flt_valid <= 1'b1;
        flt_addr  <= rd_bad ? rd_addr : wr_addr;
        flt_ch    <= rd_bad ? rd_ch : wr_ch;
        flt_wr    <= !rd_bad;
      end
    end
  end

  p_one_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_req) |-> (rd_pass ^ rd_blk));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_req) |-> (!wr_pass && !wr_blk));
  p_off_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(prot_en) |-> (!rd_blk && !wr_blk));
  p_err_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> flt_valid);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flt_valid) && !$past(flt_clr)) |-> (flt_valid && $stable(flt_addr) && $stable(flt_ch)));
  p_chan_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_req && prot_en && !wr_ch_ok) |-> wr_blk);

endmodule

// File: tb/dma_region_guard_tb_top.sv
module dma_region_guard_tb_top;
  localparam int NREG = 4, NCH = 3, AW = 32, LW = 3, RW = 2, CW = 2;

  logic clk = 0, rst_n = 0, prot_en = 0;
  logic cfg_we = 0; logic [RW-1:0] cfg_sel = 0; logic [1:0] cfg_fld = 0; logic [AW-1:0] cfg_wdata = 0;
  logic rd_req = 0, wr_req = 0; logic [CW-1:0] rd_ch = 0, wr_ch = 0;
  logic [AW-1:0] rd_addr = 0, wr_addr = 0; logic [LW-1:0] rd_len = 0, wr_len = 0;
  logic rd_pass, rd_blk, wr_pass, wr_blk, err_o, flt_clr = 0, flt_valid, flt_wr;
  logic [AW-1:0] flt_addr; logic [CW-1:0] flt_ch;

  always #5 clk = ~clk;

  dma_region_guard #(.NREG(NREG), .NCH(NCH), .AW(AW), .LW(LW)) dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  logic [19:0] m_lo [NREG], m_hi [NREG];
  logic [1:0] m_perm [NREG];
  logic [NCH-1:0] m_mask [NREG];
  bit e_fv = 0; logic [AW-1:0] e_fa = 0; int e_fc = 0; bit e_fw = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit allow(bit w, int ch, logic [31:0] a, int lm1);
    logic [32:0] last;
    if (!prot_en) return 1;
    if (ch >= NCH) return 0;
    last = {1'b0, a} + 33'(lm1);
    for (int r = 0; r < NREG; r++)
      if (m_mask[r][ch] && (w ? m_perm[r][1] : m_perm[r] != 0) &&
          a[31:12] >= m_lo[r] && last[32:12] <= {1'b0, m_hi[r]}) return 1;
    return 0;
  endfunction

  task automatic cfg(int r, int f, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = RW'(r); cfg_fld = 2'(f); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (f)
      0: m_lo[r] = d[19:0];
      1: m_hi[r] = d[19:0];
      2: m_perm[r] = d[1:0];
      default: m_mask[r] = d[NCH-1:0];
    endcase
  endtask

  task automatic win(int r, logic [19:0] lo, logic [19:0] hi, int p, int mk);
    cfg(r, 0, {12'h0, lo}); cfg(r, 1, {12'h0, hi}); cfg(r, 2, p); cfg(r, 3, mk);
  endtask

  task automatic fault_chk(string tag);
    check({tag, " flt_valid"}, flt_valid, e_fv);
    if (e_fv) begin
      check({tag, " flt_addr"}, flt_addr, e_fa);
      check({tag, " flt_ch"}, flt_ch, e_fc);
      check({tag, " flt_wr"}, flt_wr, e_fw);
    end
  endtask

  task automatic clear_flt();
    @(negedge clk); flt_clr = 1;
    @(negedge clk); flt_clr = 0; e_fv = 0;
    check("R9 cleared", flt_valid, 0);
  endtask

  task automatic acc(string tag, bit w, int ch, logic [31:0] a, int lm1);
    bit ok;
    ok = allow(w, ch, a, lm1);
    @(negedge clk);
    if (w) begin wr_req = 1; wr_ch = CW'(ch); wr_addr = a; wr_len = LW'(lm1); end
    else   begin rd_req = 1; rd_ch = CW'(ch); rd_addr = a; rd_len = LW'(lm1); end
    @(negedge clk);
    rd_req = 0; wr_req = 0;
    if (!ok && !e_fv) begin e_fv = 1; e_fa = a; e_fc = ch; e_fw = w; end
    check({tag, w ? " wr_pass" : " rd_pass"}, w ? wr_pass : rd_pass, ok);
    check({tag, w ? " wr_blk" : " rd_blk"}, w ? wr_blk : rd_blk, !ok);
    check({tag, " other bus idle R8"}, w ? (rd_pass | rd_blk) : (wr_pass | wr_blk), 0);
    check({tag, " err_o R9"}, err_o, !ok);
    fault_chk(tag);
  endtask

  task automatic sweep(string tag);
    int n = 0;
    int offs [4] = '{0, 'hFF8, 'hFFC, 'hFFF};
    int lens [3] = '{0, 3, 7};
    for (int pg = 0; pg < 6; pg++)
      for (int o = 0; o < 4; o++)
        for (int l = 0; l < 3; l++)
          for (int ch = 0; ch < 4; ch++)
            for (int w = 0; w < 2; w++) begin
              acc(tag, w[0], ch, 32'h200E0000 + 32'(pg) * 32'h1000 + 32'(offs[o]), lens[l]);
              n++;
              if (n % 37 == 0) clear_flt();
            end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin m_lo[r] = 0; m_hi[r] = 0; m_perm[r] = 0; m_mask[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rd_pass", rd_pass, 0); check("R1 rd_blk", rd_blk, 0);
    check("R1 wr_pass", wr_pass, 0); check("R1 wr_blk", wr_blk, 0);
    check("R1 err_o", err_o, 0); check("R1 flt_valid", flt_valid, 0);

    // R1: reset windows grant nothing once enabled
    prot_en = 1;
    acc("R1 empty windows", 0, 0, 32'h200E0000, 0);
    clear_flt();

    // R11 config: window map A
    win(0, 20'h200E0, 20'h200E0, 2, 3'b011);
    win(1, 20'h200E1, 20'h200E2, 1, 3'b110);
    win(2, 20'h200E3, 20'h200E3, 0, 3'b111);
    win(3, 20'h200E5, 20'h200E4, 3, 3'b111);

    // R4 boundary example
    acc("R4 inside", 1, 0, 32'h200E0FFC, 3);
    acc("R4 crosses end", 1, 0, 32'h200E0FFC, 4);
    acc("R4 at next page", 1, 0, 32'h200E1000, 0);
    clear_flt();
    // R7 span of two adjacent windows, both readable by ch1
    acc("R7 span", 0, 1, 32'h200E0FFE, 3);
    // R5 read only window refuses write
    acc("R5 read only write", 1, 1, 32'h200E1800, 0);
    acc("R5 read only read", 0, 1, 32'h200E1800, 0);
    // R6 mask excludes ch0 from window 1
    acc("R6 unmasked channel", 0, 0, 32'h200E1800, 0);
    acc("R6 ch out of range", 1, 3, 32'h200E0000, 0);
    clear_flt();

    sweep("R3 R5 R6 R7 sweep map A");
    clear_flt();

    // R6 many-to-many: map B
    win(0, 20'h200E0, 20'h200E1, 3, 3'b101);
    win(1, 20'h200E1, 20'h200E3, 2, 3'b011);
    win(2, 20'h200E4, 20'h200E4, 1, 3'b010);
    win(3, 20'h200E2, 20'h200E5, 1, 3'b100);
    sweep("R3 R5 R6 sweep map B");
    clear_flt();

    // R10 + R9 simultaneous faults: read recorded
    @(negedge clk);
    rd_req = 1; rd_ch = 1; rd_addr = 32'h10000000; rd_len = 0;
    wr_req = 1; wr_ch = 2; wr_addr = 32'h20000000; wr_len = 0;
    @(negedge clk);
    rd_req = 0; wr_req = 0;
    check("R10 rd_blk", rd_blk, 1); check("R10 wr_blk", wr_blk, 1);
    e_fv = 1; e_fa = 32'h10000000; e_fc = 1; e_fw = 0;
    fault_chk("R9 read priority");
    // R10 mixed: read passes, write blocked, sticky holds
    @(negedge clk);
    rd_req = 1; rd_ch = 0; rd_addr = 32'h200E0010; rd_len = 7;
    wr_req = 1; wr_ch = 2; wr_addr = 32'h200E4000; wr_len = 0;
    @(negedge clk);
    rd_req = 0; wr_req = 0;
    check("R10 rd_pass", rd_pass, 1); check("R10 wr_blk", wr_blk, 1);
    fault_chk("R9 sticky");
    // R9 fault in the clear cycle is recorded
    @(negedge clk);
    flt_clr = 1; wr_req = 1; wr_ch = 0; wr_addr = 32'h30000000; wr_len = 0;
    @(negedge clk);
    flt_clr = 0; wr_req = 0;
    e_fa = 32'h30000000; e_fc = 0; e_fw = 1;
    fault_chk("R9 clear and fault");
    // R4 wrap past top of address space
    clear_flt();
    win(0, 20'hFFFFF, 20'hFFFFF, 2, 3'b111);
    acc("R4 top wrap", 0, 0, 32'hFFFFFFFE, 3);
    acc("R4 top fit", 0, 0, 32'hFFFFFFFC, 3);

    // R2 disabled
    clear_flt();
    prot_en = 0;
    acc("R2 off bad addr", 1, 1, 32'h00000000, 7);
    acc("R2 off bad ch", 0, 3, 32'h12345678, 0);
    sweep("R2 off sweep");
    check("R2 no fault", flt_valid, 0);

    @(negedge clk);
    check("R8 idle", rd_pass | rd_blk | wr_pass | wr_blk, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule